// File: doc/BRIEF.md
# Thermal Limit and Alert Status Logic

This block watches two temperature channels (local and remote) and one fan tachometer period. Each time a monitoring sample arrives, it compares the values against programmed limits and records the results in two status bytes. Most status bits are sticky and are cleared by a status-read strobe. Three active-low indications follow from the stored state: a shared alert line, an over-temperature shutdown pin and a thermal-throttle pin.

The flags do not all re-arm in the same way. Range and fan-slow flags are plainly sticky. Critical and thermal flags stay quiet after a read until the temperature has dropped by a hysteresis margin (HYST, 5 degrees). The overspeed flag stays quiet until its condition has gone away. The remote-sensor fault flag holds until reset. Interrupt enables gate only the alert line and never the stored bit, and the critical alert cannot be masked.

Top module: `thermal_alert_status`

## Requirements
- R1: With start high and sample_valid high, a channel temperature at or above its high limit sets its high bit, and one at or below its low limit sets its low bit. Either bit also reports the channel's out-of-range bit. status_a bit layout: [0] local high, [1] local low, [2] remote high, [3] remote low, [4] local out-of-range, [5] remote out-of-range, [6] local critical, [7] remote critical. All comparisons are 8-bit two's complement.
- R2: Status bits are sticky and are cleared by status_rd at the next clock edge. A condition sampled in the same cycle as the read sets its bit anyway, so setting wins over clearing.
- R3: A temperature at or above its critical limit makes the channel over-temperature active. ovr_n is low while any channel is active and ovr_en is 1. The active state ends only on a sample at or below limit minus 5.
- R4: Once a read has cleared a critical or thermal bit, that bit is not set again until a sample at or below its limit minus 5 has been seen.
- R5: A temperature at or above its thermal limit drives therm_n low regardless of enables and reads. therm_n returns high on a sample at or below limit minus 5. status_b bits: [0] local thermal, [1] remote thermal.
- R6: remote_fault sampled during a monitoring cycle sets status_b[2]. A read does not clear this bit, and it forces ovr_n low until reset. It raises the alert only when ie_fault is 1.
- R7: A tach period greater than tach_slow_lim sets status_b[3]. A period less than tach_fast_lim sets status_b[4]. After a read clears bit 4, it stays clear until a sample with the period at or above tach_fast_lim.
- R8: While start is low, samples change no status bit and no pin.
- R9: alert_n is low whenever any set bit has its enable high. The enables are ie_local_range (bits a4), ie_remote_range (a5), ie_therm (b0, b1), ie_fault (b2) and ie_fan (b3, b4). Bits a6 and a7 always pull alert_n low. alert_n follows enable changes without waiting for a sample.
- R10: After reset, both status bytes are zero and alert_n, ovr_n and therm_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Monitoring enable |
| sample_valid | input | 1 | Measurement values valid this cycle |
| local_temp | input | TW | Local temperature, two's complement degrees |
| remote_temp | input | TW | Remote temperature, two's complement degrees |
| tach_period | input | TACHW | Measured fan period (larger means slower) |
| remote_fault | input | 1 | Remote sensor fault seen by the front end |
| status_rd | input | 1 | Status read strobe, clears sticky bits |
| local_hi_lim | input | TW | Local high limit |
| local_lo_lim | input | TW | Local low limit |
| local_crit_lim | input | TW | Local critical limit |
| local_therm_lim | input | TW | Local thermal limit |
| remote_hi_lim | input | TW | Remote high limit |
| remote_lo_lim | input | TW | Remote low limit |
| remote_crit_lim | input | TW | Remote critical limit |
| remote_therm_lim | input | TW | Remote thermal limit |
| tach_slow_lim | input | TACHW | Period above this means the fan is slow |
| tach_fast_lim | input | TACHW | Period below this means overspeed |
| ovr_en | input | 1 | Lets critical temperature drive ovr_n |
| ie_local_range | input | 1 | Alert enable, local out-of-range |
| ie_remote_range | input | 1 | Alert enable, remote out-of-range |
| ie_therm | input | 1 | Alert enable, thermal bits |
| ie_fault | input | 1 | Alert enable, remote fault |
| ie_fan | input | 1 | Alert enable, fan slow and overspeed |
| status_a | output | 8 | Temperature status byte |
| status_b | output | 8 | Thermal, fault and fan status byte |
| alert_n | output | 1 | Active-low alert line |
| ovr_n | output | 1 | Active-low over-temperature shutdown |
| therm_n | output | 1 | Active-low thermal throttle |

## Verification
The key collision is a status read and a monitoring sample landing on the same clock edge. In that case the clear must not hide a condition that the sample has just seen again. The bench provokes this by raising status_rd together with sample_valid while new high and low violations are present, and expects the newly found bits to remain set. A second overlap is a read of an active critical flag while its pin stays asserted. Later samples above the limit must then leave the flag clear, but the pin must stay low until the hysteresis release point is reached.

// File: rtl/thermal_alert_status.sv
module thermal_alert_status #(
  parameter int TW    = 8,
  parameter int TACHW = 16,
  parameter int HYST  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sample_valid,
  input  logic [TW-1:0]    local_temp,
  input  logic [TW-1:0]    remote_temp,
  input  logic [TACHW-1:0] tach_period,
  input  logic             remote_fault,
  input  logic             status_rd,
  input  logic [TW-1:0]    local_hi_lim,
  input  logic [TW-1:0]    local_lo_lim,
  input  logic [TW-1:0]    local_crit_lim,
  input  logic [TW-1:0]    local_therm_lim,
  input  logic [TW-1:0]    remote_hi_lim,
  input  logic [TW-1:0]    remote_lo_lim,
  input  logic [TW-1:0]    remote_crit_lim,
  input  logic [TW-1:0]    remote_therm_lim,
  input  logic [TACHW-1:0] tach_slow_lim,
  input  logic [TACHW-1:0] tach_fast_lim,
  input  logic             ovr_en,
  input  logic             ie_local_range,
  input  logic             ie_remote_range,
  input  logic             ie_therm,
  input  logic             ie_fault,
  input  logic             ie_fan,
  output logic [7:0]       status_a,
  output logic [7:0]       status_b,
  output logic             alert_n,
  output logic             ovr_n,
  output logic             therm_n
);

  localparam int NCH = 2;
  localparam logic signed [TW:0] HYST_S = (TW+1)'(HYST);

  logic mon;
  assign mon = start & sample_valid;

  logic [NCH-1:0][TW-1:0] tv, hil, lol, crl, thl;
  assign tv  = {remote_temp,      local_temp};
  assign hil = {remote_hi_lim,    local_hi_lim};
  assign lol = {remote_lo_lim,    local_lo_lim};
  assign crl = {remote_crit_lim,  local_crit_lim};
  assign thl = {remote_therm_lim, local_therm_lim};

  logic [NCH-1:0] ge_hi, le_lo, ge_crit, rel_crit, ge_th, rel_th;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ge_hi[c]    = $signed(tv[c]) >= $signed(hil[c]);
      le_lo[c]    = $signed(tv[c]) <= $signed(lol[c]);
      ge_crit[c]  = $signed(tv[c]) >= $signed(crl[c]);
      ge_th[c]    = $signed(tv[c]) >= $signed(thl[c]);
      rel_crit[c] = $signed({tv[c][TW-1], tv[c]}) <=
                    ($signed({crl[c][TW-1], crl[c]}) - HYST_S);
      rel_th[c]   = $signed({tv[c][TW-1], tv[c]}) <=
                    ($signed({thl[c][TW-1], thl[c]}) - HYST_S);
    end
  end

  logic [NCH-1:0] f_hi, f_lo, f_crit, f_th;
  logic [NCH-1:0] crit_act, th_act, crit_arm, th_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_hi     <= '0;
      f_lo     <= '0;
      f_crit   <= '0;
      f_th     <= '0;
      crit_act <= '0;
      th_act   <= '0;
      crit_arm <= '1;
      th_arm   <= '1;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (status_rd) begin
          f_hi[c]   <= 1'b0;
          f_lo[c]   <= 1'b0;
          f_crit[c] <= 1'b0;
          f_th[c]   <= 1'b0;
          if (f_crit[c]) crit_arm[c] <= 1'b0;
          if (f_th[c])   th_arm[c]   <= 1'b0;
        end
        if (mon) begin
          if (ge_hi[c]) f_hi[c] <= 1'b1;
          if (le_lo[c]) f_lo[c] <= 1'b1;
          if (ge_crit[c]) begin
            crit_act[c] <= 1'b1;
            if (crit_arm[c]) f_crit[c] <= 1'b1;
          end else if (rel_crit[c]) begin
            crit_act[c] <= 1'b0;
            crit_arm[c] <= 1'b1;
          end
          if (ge_th[c]) begin
            th_act[c] <= 1'b1;
            if (th_arm[c]) f_th[c] <= 1'b1;
          end else if (rel_th[c]) begin
            th_act[c] <= 1'b0;
            th_arm[c] <= 1'b1;
          end
        end
      end
    end
  end

  logic f_slow, f_over, over_arm, f_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_slow   <= 1'b0;
      f_over   <= 1'b0;
      over_arm <= 1'b1;
    end else begin
      if (status_rd) begin
        f_slow <= 1'b0;
        f_over <= 1'b0;
        if (f_over) over_arm <= 1'b0;
      end
      if (mon) begin
        if (tach_period > tach_slow_lim) f_slow <= 1'b1;
        if (tach_period < tach_fast_lim) begin
          if (over_arm) f_over <= 1'b1;
        end else begin
          over_arm <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    f_fault <= 1'b0;
    else if (mon && remote_fault)  f_fault <= 1'b1;
  end

  logic l_oor, r_oor;
  assign l_oor = f_hi[0] | f_lo[0];
  assign r_oor = f_hi[1] | f_lo[1];

  assign status_a = {f_crit[1], f_crit[0], r_oor, l_oor,
                     f_lo[1], f_hi[1], f_lo[0], f_hi[0]};
  assign status_b = {3'b000, f_over, f_slow, f_fault, f_th[1], f_th[0]};

  assign alert_n = ~((ie_local_range  & l_oor) |
                     (ie_remote_range & r_oor) |
                     (|f_crit) |
                     (ie_therm & (|f_th)) |
                     (ie_fault & f_fault) |
                     (ie_fan & (f_slow | f_over)));

  assign ovr_n   = ~((ovr_en & (|crit_act)) | f_fault);
  assign therm_n = ~(|th_act);

endmodule

// File: rtl/thermal_alert_status_chk.sv
module thermal_alert_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sample_valid,
  input logic       status_rd,
  input logic       ovr_en,
  input logic [7:0] status_a,
  input logic [7:0] status_b,
  input logic       alert_n,
  input logic       ovr_n,
  input logic       therm_n
);

  p_read_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sample_valid) |=> (status_a == 8'h00 && status_b[4:3] == 2'b00 && status_b[1:0] == 2'b00));

  p_ovr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && !status_b[2]) |-> ovr_n);

  p_therm_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_b[0] | status_b[1]) |-> !therm_n);

  p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_b[2] |=> status_b[2]);

  p_fault_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_b[2] |-> !ovr_n);

  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !status_rd) |=> ($stable(status_a) && $stable(status_b)));

  p_crit_alert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_a[6] | status_a[7]) |-> !alert_n);

endmodule

bind thermal_alert_status thermal_alert_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
  .status_rd(status_rd), .ovr_en(ovr_en), .status_a(status_a),
  .status_b(status_b), .alert_n(alert_n), .ovr_n(ovr_n), .therm_n(therm_n)
);

// File: tb/tb_thermal_alert_status.sv
`timescale 1ns/1ps
module tb_thermal_alert_status;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sample_valid = 1'b0, status_rd = 1'b0;
  logic [7:0] local_temp = 8'd30, remote_temp = 8'd30;
  logic [15:0] tach_period = 16'd500;
  logic remote_fault = 1'b0;
  logic ovr_en = 1'b1;
  logic ie_lr = 1'b1, ie_rr = 1'b1, ie_th = 1'b1, ie_flt = 1'b0, ie_fan = 1'b0;
  logic [7:0] status_a, status_b;
  logic alert_n, ovr_n, therm_n;

  thermal_alert_status dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .local_temp(local_temp), .remote_temp(remote_temp), .tach_period(tach_period),
    .remote_fault(remote_fault), .status_rd(status_rd),
    .local_hi_lim(8'd50), .local_lo_lim(8'd10), .local_crit_lim(8'd80), .local_therm_lim(8'd70),
    .remote_hi_lim(8'd60), .remote_lo_lim(8'd0), .remote_crit_lim(8'd90), .remote_therm_lim(8'd75),
    .tach_slow_lim(16'd1000), .tach_fast_lim(16'd200), .ovr_en(ovr_en),
    .ie_local_range(ie_lr), .ie_remote_range(ie_rr), .ie_therm(ie_th),
    .ie_fault(ie_flt), .ie_fan(ie_fan),
    .status_a(status_a), .status_b(status_b), .alert_n(alert_n),
    .ovr_n(ovr_n), .therm_n(therm_n)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic alert_n;
    logic ovr_n;
    logic therm_n;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic sv, input logic [7:0] ea, input logic [7:0] eb,
                      input logic eal, input logic eov, input logic eth, input string tag);
    exp_t e;
    @(negedge clk);
    status_rd = rd;
    sample_valid = sv;
    e.a = ea; e.b = eb; e.alert_n = eal; e.ovr_n = eov; e.therm_n = eth; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #2;
    status_rd = 1'b0;
    sample_valid = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp({e.tag, " status_a"}, 32'(status_a), 32'(e.a));
      cmp({e.tag, " status_b"}, 32'(status_b), 32'(e.b));
      cmp({e.tag, " alert_n"},  32'(alert_n),  32'(e.alert_n));
      cmp({e.tag, " ovr_n"},    32'(ovr_n),    32'(e.ovr_n));
      cmp({e.tag, " therm_n"},  32'(therm_n),  32'(e.therm_n));
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10 reset status_a", 32'(status_a), 0);
    cmp("R10 reset status_b", 32'(status_b), 0);
    cmp("R10 reset pins", 32'({alert_n, ovr_n, therm_n}), 32'h7);
    rst_n = 1'b1;

    local_temp = 8'd55;
    step(0, 1, 8'h00, 8'h00, 1, 1, 1, "R8 start low ignores sample");
    start = 1'b1; local_temp = 8'd30;
    step(0, 1, 8'h00, 8'h00, 1, 1, 1, "R1 in range");
    local_temp = 8'd50;
    step(0, 1, 8'h11, 8'h00, 0, 1, 1, "R1 high at limit");
    step(0, 0, 8'h11, 8'h00, 0, 1, 1, "R2 sticky");
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R2 read clears");
    local_temp = 8'd10;
    step(0, 1, 8'h12, 8'h00, 0, 1, 1, "R1 low at limit");
    local_temp = 8'd55; remote_temp = 8'd0;
    step(1, 1, 8'h39, 8'h00, 0, 1, 1, "R2 read with sample set wins");
    local_temp = 8'd30; remote_temp = 8'd30;
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R2 read");
    ie_rr = 1'b0; remote_temp = 8'd65;
    step(0, 1, 8'h24, 8'h00, 1, 1, 1, "R9 masked remote range");
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R2 read");
    ie_rr = 1'b1; remote_temp = 8'd30; ie_lr = 1'b0; ie_th = 1'b0;
    local_temp = 8'd80;
    step(0, 1, 8'h51, 8'h01, 0, 0, 0, "R3 R9 critical unmaskable");
    step(1, 0, 8'h00, 8'h00, 1, 0, 0, "R5 read keeps pins");
    step(0, 1, 8'h11, 8'h00, 1, 0, 0, "R4 no re-set while hot");
    step(1, 0, 8'h00, 8'h00, 1, 0, 0, "R4 read");
    local_temp = 8'd76;
    step(0, 1, 8'h11, 8'h00, 1, 0, 0, "R3 hold above release");
    step(1, 0, 8'h00, 8'h00, 1, 0, 0, "R3 read");
    local_temp = 8'd75;
    step(0, 1, 8'h11, 8'h00, 1, 1, 0, "R3 release at limit minus 5");
    step(1, 0, 8'h00, 8'h00, 1, 1, 0, "R5 read");
    local_temp = 8'd65;
    step(0, 1, 8'h11, 8'h00, 1, 1, 1, "R5 therm release");
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R4 read");
    local_temp = 8'd72;
    step(0, 1, 8'h11, 8'h01, 1, 1, 0, "R4 R9 therm rearmed masked");
    ie_th = 1'b1;
    step(0, 0, 8'h11, 8'h01, 0, 1, 0, "R9 enable change");
    local_temp = 8'd30;
    step(0, 1, 8'h11, 8'h01, 0, 1, 1, "R5 pin released bit sticky");
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R2 read");
    ovr_en = 1'b0; remote_temp = 8'd95;
    step(0, 1, 8'hA4, 8'h02, 0, 1, 0, "R3 ovr disabled");
    remote_temp = 8'd30;
    step(0, 1, 8'hA4, 8'h02, 0, 1, 1, "R5 remote release");
    step(1, 0, 8'h00, 8'h00, 1, 1, 1, "R2 read");
    ovr_en = 1'b1; remote_fault = 1'b1;
    step(0, 1, 8'h00, 8'h04, 1, 0, 1, "R6 fault masked");
    remote_fault = 1'b0;
    step(1, 0, 8'h00, 8'h04, 1, 0, 1, "R6 fault survives read");
    ie_flt = 1'b1;
    step(0, 0, 8'h00, 8'h04, 0, 0, 1, "R6 fault enabled");
    ie_flt = 1'b0; ie_fan = 1'b1; tach_period = 16'd1001;
    step(0, 1, 8'h00, 8'h0C, 0, 0, 1, "R7 slow");
    step(1, 0, 8'h00, 8'h04, 1, 0, 1, "R7 read");
    tach_period = 16'd1000;
    step(0, 1, 8'h00, 8'h04, 1, 0, 1, "R7 slow limit exclusive");
    tach_period = 16'd199;
    step(0, 1, 8'h00, 8'h14, 0, 0, 1, "R7 overspeed");
    step(1, 0, 8'h00, 8'h04, 1, 0, 1, "R7 read");
    step(0, 1, 8'h00, 8'h04, 1, 0, 1, "R7 overspeed not re-set");
    tach_period = 16'd200;
    step(0, 1, 8'h00, 8'h04, 1, 0, 1, "R7 overspeed cleared condition");
    tach_period = 16'd150;
    step(0, 1, 8'h00, 8'h14, 0, 0, 1, "R7 overspeed rearmed");

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp("R10 reset clears fault", 32'(status_b), 0);
    cmp("R10 reset ovr_n", 32'(ovr_n), 1);
    cmp("R10 reset alert_n", 32'(alert_n), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule